// File: doc/BRIEF.md
# Decoupled Instruction Fetch Unit

This block is the front of a pipelined processor. It owns the fetch program counter and sends one address at a time to an instruction cache port. A cache hit answers in the next cycle. A miss answers only after the whole line has been filled from memory. Each word that comes back is paired with the address it was fetched from and pushed into a small output queue. Decode drains that queue through a valid/ready stream.

When the branch unit resolves a taken branch or a jump, it pulses a redirect along with the new target. The unit then drops every younger instruction it holds and restarts fetch at the target. A fill for a wrong-path address cannot be abandoned, so the unit waits for it to finish and throws the word away before it issues the target address.

The output stream follows the usual rules. An instruction moves only in a cycle where both valid and ready are high. While valid is high and ready is low, the offered PC and instruction stay frozen. Back-pressure stops new cache requests once the queue has no room. A response that was already in flight when the queue filled is parked in a hold register and never lost.

Top module: `fetch_unit`

## Requirements
- R1: While reset is asserted `out_valid` is 0; in the first cycle after reset release a cache request is issued with address equal to `reset_pc`.
- R2: Every delivered instruction carries the address it was fetched from together with the cache word returned for that address, and successive deliveries without an intervening redirect have addresses 4 apart.
- R3: At most one cache request is outstanding; no request is issued while an earlier one has not yet received `ic_rsp_valid`, although a new request may be issued in the same cycle a response arrives.
- R4: With `out_ready` held high and the cache hitting, one instruction is delivered per cycle.
- R5: On a miss nothing is delivered until the fill completes; the instruction appears on the output the cycle after its response is accepted.
- R6: A redirect that arrives while a fetch is outstanding withholds all new requests until that response returns, discards that response, and then issues a request at the redirect target in the following cycle.
- R7: `out_valid` is 0 in any cycle where `redirect` is high and also in the cycle after it, because all queued instructions are flushed.
- R8: While `out_valid` is 1 and `out_ready` is 0 (no redirect), the next cycle still shows `out_valid` high with unchanged `out_pc` and `out_instr`.
- R9: A response that arrives when the output queue cannot accept it is held and delivered later in program order; no instruction is lost or duplicated under any ready pattern.
- R10: A redirect while a response is being held drops that response; the first instruction delivered afterwards is the redirect target.
- R11: With `out_ready` held low after a redirect, exactly SKID_DEPTH + 1 cache requests are issued (queue entries plus the hold register) and then none until the output drains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_pc | input | ADDR_W | First fetch address, loaded during reset |
| redirect | input | 1 | Taken branch or jump, one-cycle pulse |
| redirect_pc | input | ADDR_W | Target address accompanying `redirect` |
| ic_req_valid | output | 1 | Cache request issued this cycle |
| ic_req_addr | output | ADDR_W | Address of the cache request |
| ic_rsp_valid | input | 1 | Cache returns the word for the outstanding request |
| ic_rsp_data | input | INSTR_W | Returned instruction word |
| out_valid | output | 1 | An instruction is offered downstream |
| out_ready | input | 1 | Downstream accepts the offered instruction |
| out_pc | output | ADDR_W | Address of the offered instruction |
| out_instr | output | INSTR_W | Offered instruction word |

## Verification
The bench uses the default build: 32-bit addresses and words and a two-entry output queue. The full-stall case therefore ends after three requests, which a short directed test can count exactly. The cache model answers hits in one cycle and misses in six, and it treats each line as sixteen words. With those settings the bench can see a one-per-cycle streak inside a line and a miss bubble at a line crossing. It can also land a redirect in the middle of a fill and compare the exact cycle of the restart request with the cycle of the fill's completion.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  // Sequencer phases: ready to issue, awaiting cache word, parking a word
  typedef enum logic [1:0] {
    FS_ISSUE = 2'd0,
    FS_WAIT  = 2'd1,
    FS_PARK  = 2'd2
  } fetch_state_e;

endpackage

// File: rtl/fetch_skid_buf.sv
module fetch_skid_buf #(
  parameter int W     = 64,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_SLOT = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);

  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] fill_q, fill_nx;
  logic          room_q;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + PW'(1);
  endfunction

  assign out_valid = (fill_q != '0);
  assign out_data  = slot_q[rd_q];
  assign in_ready  = room_q;
  assign do_push   = in_valid && room_q;
  assign do_pop    = out_valid && out_ready;
  assign fill_nx   = fill_q + CW'(do_push) - CW'(do_pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
      room_q <= 1'b1;
    end else if (flush) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
      room_q <= 1'b1;
    end else begin
      if (do_push) wr_q <= wrap_inc(wr_q);
      if (do_pop)  rd_q <= wrap_inc(rd_q);
      fill_q <= fill_nx;
      room_q <= (fill_nx < FULL_CNT);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) slot_q[wr_q] <= in_data;
  end

  // R11: occupancy never exceeds the configured depth
  p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FULL_CNT);

  // R8: a stalled head stays put unless a flush intervenes
  p_out_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=>
      (flush || (out_valid && $stable(out_data))));

endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fetch_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reset_pc,
  input  logic               redirect,
  input  logic [ADDR_W-1:0]  redirect_pc,
  output logic               ic_req_valid,
  output logic [ADDR_W-1:0]  ic_req_addr,
  input  logic               ic_rsp_valid,
  input  logic [INSTR_W-1:0] ic_rsp_data,
  output logic               push_valid,
  input  logic               push_ready,
  output logic [ADDR_W-1:0]  push_pc,
  output logic [INSTR_W-1:0] push_instr
);

  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(4);

  fetch_state_e        state_q;
  logic [ADDR_W-1:0]   pc_q, pc_inc;
  logic                stale_q;
  logic [INSTR_W-1:0]  park_q;
  logic                rsp_live;

  assign pc_inc   = pc_q + PC_STEP;
  // A response counts only if it belongs to the current path
  assign rsp_live = (state_q == FS_WAIT) && ic_rsp_valid && !stale_q && !redirect;

  always_comb begin
    push_valid = rsp_live || ((state_q == FS_PARK) && !redirect);
    push_pc    = pc_q;
    push_instr = (state_q == FS_PARK) ? park_q : ic_rsp_data;
    // Chain the next request into the cycle a good response is queued
    ic_req_valid = !redirect && push_ready &&
                   ((state_q == FS_ISSUE) || rsp_live);
    ic_req_addr  = (state_q == FS_ISSUE) ? pc_q : pc_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_ISSUE;
      pc_q    <= reset_pc;
      stale_q <= 1'b0;
      park_q  <= '0;
    end else begin
      unique case (state_q)
        FS_ISSUE: begin
          if (redirect)          pc_q <= redirect_pc;
          else if (ic_req_valid) state_q <= FS_WAIT;
        end
        FS_WAIT: begin
          if (ic_rsp_valid) begin
            stale_q <= 1'b0;
            if (stale_q || redirect) begin
              state_q <= FS_ISSUE;
              if (redirect) pc_q <= redirect_pc;
            end else if (push_ready) begin
              pc_q <= pc_inc;
            end else begin
              park_q  <= ic_rsp_data;
              state_q <= FS_PARK;
            end
          end else if (redirect) begin
            pc_q    <= redirect_pc;
            stale_q <= 1'b1;
          end
        end
        FS_PARK: begin
          if (redirect) begin
            pc_q    <= redirect_pc;
            state_q <= FS_ISSUE;
          end else if (push_ready) begin
            pc_q    <= pc_inc;
            state_q <= FS_ISSUE;
          end
        end
        default: state_q <= FS_ISSUE;
      endcase
    end
  end

  // Port-level count of requests minus responses, for checking only
  logic [1:0] chk_open_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_open_q <= '0;
    else        chk_open_q <= chk_open_q + 2'(ic_req_valid) - 2'(ic_rsp_valid);
  end

  // R3: a single fetch in flight at any time
  p_single_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_open_q == 2'd1 && !ic_rsp_valid) |-> !ic_req_valid);

  // R9: an offered but refused word is still offered unchanged next cycle
  p_held_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready && !redirect) |=>
      (redirect || (push_valid && $stable(push_pc) && $stable(push_instr))));

endmodule

// File: rtl/fetch_unit.sv
module fetch_unit #(
  parameter int ADDR_W     = 32,
  parameter int INSTR_W    = 32,
  parameter int SKID_DEPTH = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reset_pc,
  input  logic               redirect,
  input  logic [ADDR_W-1:0]  redirect_pc,
  output logic               ic_req_valid,
  output logic [ADDR_W-1:0]  ic_req_addr,
  input  logic               ic_rsp_valid,
  input  logic [INSTR_W-1:0] ic_rsp_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ADDR_W-1:0]  out_pc,
  output logic [INSTR_W-1:0] out_instr
);

  localparam int ENTRY_W = ADDR_W + INSTR_W;

  logic               push_valid, push_ready;
  logic [ADDR_W-1:0]  push_pc;
  logic [INSTR_W-1:0] push_instr;
  logic               q_valid;
  logic [ENTRY_W-1:0] q_data;

  fetch_seq #(
    .ADDR_W  (ADDR_W),
    .INSTR_W (INSTR_W)
  ) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .reset_pc     (reset_pc),
    .redirect     (redirect),
    .redirect_pc  (redirect_pc),
    .ic_req_valid (ic_req_valid),
    .ic_req_addr  (ic_req_addr),
    .ic_rsp_valid (ic_rsp_valid),
    .ic_rsp_data  (ic_rsp_data),
    .push_valid   (push_valid),
    .push_ready   (push_ready),
    .push_pc      (push_pc),
    .push_instr   (push_instr)
  );

  fetch_skid_buf #(
    .W     (ENTRY_W),
    .DEPTH (SKID_DEPTH)
  ) skid_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (redirect),
    .in_valid  (push_valid),
    .in_ready  (push_ready),
    .in_data   ({push_pc, push_instr}),
    .out_valid (q_valid),
    .out_ready (out_ready),
    .out_data  (q_data)
  );

  // Queued entries are younger than the redirecting branch: hide them
  assign out_valid = q_valid && !redirect;
  assign out_pc    = q_data[ENTRY_W-1:INSTR_W];
  assign out_instr = q_data[INSTR_W-1:0];

  // R7: the queue is empty in the cycle following a redirect
  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !out_valid);

endmodule

// File: tb/fetch_unit_tb_top.sv
`timescale 1ns/1ps
module fetch_unit_tb_top;

  localparam int          MISS_LAT = 6;
  localparam int          DEPTH    = 2;
  localparam logic [31:0] RESET_PC = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        redirect = 1'b0;
  logic [31:0] redirect_pc = '0;
  logic        ic_req_valid;
  logic [31:0] ic_req_addr;
  logic        ic_rsp_valid = 1'b0;
  logic [31:0] ic_rsp_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_pc, out_instr;

  always #2.5 clk = ~clk;

  fetch_unit #(.ADDR_W(32), .INSTR_W(32), .SKID_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .reset_pc(RESET_PC),
    .redirect(redirect), .redirect_pc(redirect_pc),
    .ic_req_valid(ic_req_valid), .ic_req_addr(ic_req_addr),
    .ic_rsp_valid(ic_rsp_valid), .ic_rsp_data(ic_rsp_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_pc(out_pc), .out_instr(out_instr)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, cyc0 = 0;
  int req_count = 0, n_out = 0, last_req_cyc = 0, last_rsp_cyc = 0, last_out_cyc = 0;
  logic [31:0] last_req_addr = '0, raddr = '0, exp_pc = RESET_PC, first_pc = '0;
  logic [25:0] last_line = '0;
  bit busy = 0, have_line = 0, watch_first = 0, prev_stall = 0, done = 0;
  int rcnt = 0;
  logic [31:0] prev_pc = '0, prev_instr = '0;

  function automatic logic [31:0] word_of(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One cycle: cache model, stimulus, then output checks before the edge
  task automatic tick(input bit rdy, input bit redir, input logic [31:0] tgt);
    @(negedge clk);
    cyc++;
    ic_rsp_valid = 1'b0;
    if (busy) begin
      rcnt--;
      if (rcnt == 0) begin
        ic_rsp_valid = 1'b1;
        ic_rsp_data  = word_of(raddr);
        busy = 0; have_line = 1; last_line = raddr[31:6];
        last_rsp_cyc = cyc;
      end
    end
    out_ready = rdy; redirect = redir; redirect_pc = tgt;
    if (redir) begin exp_pc = tgt; watch_first = 1; end
    #1;
    if (redir) chk(out_valid == 1'b0, "R7", "out_valid in redirect cycle", 32'(out_valid), 0);
    if (rst_n && ic_req_valid) begin
      chk(!busy, "R3", "request while one outstanding", ic_req_addr, raddr);
      busy = 1; raddr = ic_req_addr;
      rcnt = (have_line && last_line == ic_req_addr[31:6]) ? 1 : MISS_LAT;
      req_count++; last_req_addr = ic_req_addr; last_req_cyc = cyc;
    end
    if (prev_stall && !redir) begin
      chk(out_valid && out_pc == prev_pc, "R8", "stalled pc held", out_pc, prev_pc);
      chk(out_instr == prev_instr, "R8", "stalled instr held", out_instr, prev_instr);
    end
    prev_stall = out_valid && !out_ready && !redir;
    prev_pc = out_pc; prev_instr = out_instr;
    if (out_valid && out_ready) begin
      n_out++;
      chk(out_pc == exp_pc, "R2", "delivered pc", out_pc, exp_pc);
      chk(out_instr == word_of(exp_pc), "R2", "delivered instr", out_instr, word_of(exp_pc));
      if (watch_first) begin first_pc = out_pc; watch_first = 0; end
      exp_pc = exp_pc + 32'd4;
      last_out_cyc = cyc;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) tick(1, 0, '0);
    chk(out_valid == 1'b0, "R1", "out_valid during reset", 32'(out_valid), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    cyc0 = cyc;
    tick(1, 0, '0);
    chk(req_count == 1 && last_req_cyc == cyc0 + 1, "R1", "first request cycle",
        32'(last_req_cyc), 32'(cyc0 + 1));
    chk(last_req_addr == RESET_PC, "R1", "first request address", last_req_addr, RESET_PC);
  endtask

  task automatic t_stream();
    int base = n_out, c1 = 0, c8 = 0;
    for (int i = 0; i < 200 && n_out < base + 20; i++) begin
      tick(1, 0, '0);
      if (n_out == base + 1 && c1 == 0) c1 = cyc;
      if (n_out == base + 8 && c8 == 0) c8 = cyc;
    end
    chk(c1 == cyc0 + MISS_LAT + 2, "R5", "first delivery after miss fill",
        32'(c1), 32'(cyc0 + MISS_LAT + 2));
    chk(c8 - c1 == 7, "R4", "eight hits in eight cycles", 32'(c8 - c1), 7);
    chk(n_out == base + 20, "R2", "stream length", 32'(n_out - base), 20);
  endtask

  task automatic t_backpressure();
    int base = n_out;
    for (int i = 0; i < 90; i++) tick((i % 6) < 3, 0, '0);
    chk(n_out - base >= 20, "R9", "deliveries under back-pressure", 32'(n_out - base), 20);
  endtask

  task automatic t_stall_and_park();
    int base;
    tick(0, 1, 32'h0000_3000);
    base = req_count;
    repeat (25) tick(0, 0, '0);
    chk(req_count - base == DEPTH + 1, "R11", "requests under full stall",
        32'(req_count - base), 32'(DEPTH + 1));
    tick(0, 1, 32'h0000_5000);
    base = n_out;
    for (int i = 0; i < 100 && n_out < base + 4; i++) tick(1, 0, '0);
    chk(first_pc == 32'h0000_5000, "R10", "first pc after parked drop", first_pc, 32'h0000_5000);
  endtask

  task automatic t_redirect_fill();
    int base;
    tick(1, 1, 32'h0000_7000);
    for (int i = 0; i < 40 && !(busy && raddr == 32'h0000_7000); i++) tick(1, 0, '0);
    tick(1, 0, '0);
    chk(busy, "R6", "fill still in progress", 32'(busy), 1);
    tick(1, 1, 32'h0000_9000);
    base = req_count;
    for (int i = 0; i < 40 && req_count == base; i++) tick(1, 0, '0);
    chk(last_req_addr == 32'h0000_9000, "R6", "restart address", last_req_addr, 32'h0000_9000);
    chk(last_req_cyc == last_rsp_cyc + 1, "R6", "restart cycle after fill",
        32'(last_req_cyc), 32'(last_rsp_cyc + 1));
    base = n_out;
    for (int i = 0; i < 60 && n_out < base + 3; i++) tick(1, 0, '0);
    chk(first_pc == 32'h0000_9000, "R6", "first pc after wrong-path fill", first_pc, 32'h0000_9000);
  endtask

  task automatic t_redirect_flush();
    int base;
    repeat (5) tick(0, 0, '0);
    chk(out_valid == 1'b1, "R7", "queue holds entries before redirect", 32'(out_valid), 1);
    tick(0, 1, 32'h0000_B000);
    tick(0, 0, '0);
    chk(out_valid == 1'b0, "R7", "queue empty after redirect", 32'(out_valid), 0);
    base = n_out;
    for (int i = 0; i < 60 && n_out < base + 3; i++) tick(1, 0, '0);
    chk(first_pc == 32'h0000_B000, "R7", "first pc after flush", first_pc, 32'h0000_B000);
  endtask

  initial begin
    t_reset();
    t_stream();
    t_backpressure();
    t_stall_and_park();
    t_redirect_fill();
    t_redirect_flush();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule